// File: doc/BRIEF.md
# Half-Duplex Line Direction Arbiter

This block relays one half-duplex serial line between two open-drain ports: a card-facing line and a host-facing line. A chip uses three copies of it, one for the data line and one for each of the two auxiliary lines. Each port has a line input and a drive-low output. When a port is released, the line is pulled high by the external pull-up.

When relaying is allowed, the arbiter waits in an idle state. The first port that shows a falling edge becomes the source. The opposite port then copies the source's low level by pulling its own line low. When the source port rises again, both outputs are released and the arbiter goes back to idle. Software does not set the direction; the line traffic sets it.

The card-facing line is held low until the power-up sequencer allows reception. The host-facing line is released from reset onward. Both line inputs pass through a synchronizer of configurable depth before edge detection.

Top module: `io_dir_arbiter`

## Requirements
- R1: During reset and after it, while `rx_enable` is 0, `card_drive_lo` is 1 and `host_drive_lo` is 0.
- R2: While `rx_enable` is 0, `card_drive_lo` stays 1 and no direction is captured, whatever `relay_en` and the line levels are.
- R3: From idle, with `relay_en` and `rx_enable` both 1, a falling edge on the card line makes `host_drive_lo` 1 for as long as the card line stays low. `card_drive_lo` stays 0.
- R4: From idle, with relaying active, a falling edge on the host line makes `card_drive_lo` 1 for as long as the host line stays low. `host_drive_lo` stays 0.
- R5: A rising edge on the current source line releases both drive outputs and returns the arbiter to idle. A later falling edge on either port is captured again.
- R6: When both lines fall in the same cycle, the card side becomes the source.
- R7: Only a fresh falling edge seen in idle captures a direction. A line that is still held low when a transfer ends does not cause a capture, so both outputs stay 0.
- R8: Clearing `relay_en` releases both drive outputs in the same cycle, with no clock edge needed, and returns the arbiter to idle. Setting `relay_en` again while a line is still low captures nothing.
- R9: While `relay_en` is 0, falling edges on either line drive nothing.
- R10: A line change reaches the arbiter only after `SYNC_STAGES` clock edges. A falling card edge shows on `host_drive_lo` on the `SYNC_STAGES+1`-th rising edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| relay_en | input | 1 | Relay enable bit; 0 releases both outputs at once |
| rx_enable | input | 1 | Reception allowed by the power-up sequencer |
| card_in | input | 1 | Level of the card-facing line (asynchronous) |
| host_in | input | 1 | Level of the host-facing line (asynchronous) |
| card_drive_lo | output | 1 | 1 pulls the card-facing line low |
| host_drive_lo | output | 1 | 1 pulls the host-facing line low |

## Verification
The bench builds the arbiter with `SYNC_STAGES` set to 3 instead of the default 2. This makes the latency check of R10 depend on the parameter rather than on a fixed constant. It also shows that the echo of the arbiter's own drive, which comes back through the deeper synchronizer, never looks like a fresh capture edge. The line models are wired-AND (open-drain), so every transfer loops back through the arbiter's own inputs.

// File: rtl/io_arb_pkg.sv
// Shared types for the line direction arbiter.
// Assumes: the line encoding is 1 = released (pulled high), 0 = driven low.
package io_arb_pkg;

    // Arbiter direction states
    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_C2H    = 2'd1,
        ARB_H2C    = 2'd2
    } arb_state_t;

    // Index of each line in the synchronizer bank
    localparam int LINE_CARD  = 0;
    localparam int LINE_HOST  = 1;
    localparam int NUM_LINES  = 2;

endpackage

// File: rtl/io_line_sync.sv
// Bank of line synchronizers with edge detection.
// Each line passes through SYNC_STAGES flip-flops. The last stage is then
// compared with its previous value to produce single-cycle fall and rise pulses.
// Assumes: SYNC_STAGES >= 2. Lines reset to the released (high) level.
module io_line_sync #(
    parameter int LINES       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] fall_o,
    output logic [LINES-1:0] rise_o
);

    localparam int LAST = SYNC_STAGES - 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [LAST:0] stg_q;
        logic          prev_q;

        // Shift the raw line through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) stg_q <= '1;
            else        stg_q <= {stg_q[LAST-1:0], line_i[g]};
        end

        // Remember the last synchronized level for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= stg_q[LAST];
        end

        // Decode level and edges of the synchronized line
        always_comb begin
            level_o[g] = stg_q[LAST];
            fall_o[g]  = prev_q & ~stg_q[LAST];
            rise_o[g]  = ~prev_q & stg_q[LAST];
        end
    end

endmodule

// File: rtl/io_dir_fsm.sv
// Direction state machine for the half-duplex relay.
// From idle, the first synchronized falling edge picks the source side; the
// card side wins a tie. A rising edge on the source side, or loss of the
// active qualifier, returns the machine to idle. Edges on the copying side
// are not looked at while a direction is held.
// Assumes: edge inputs are single-cycle pulses from the synchronizer.
module io_dir_fsm
    import io_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic       card_fall_i,
    input  logic       card_rise_i,
    input  logic       host_fall_i,
    input  logic       host_rise_i,
    output arb_state_t state_o
);

    arb_state_t state_q;
    arb_state_t state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (!active_i) begin
            state_d = ARB_IDLE;
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    if (card_fall_i)      state_d = ARB_C2H;
                    else if (host_fall_i) state_d = ARB_H2C;
                end
                ARB_C2H:  if (card_rise_i) state_d = ARB_IDLE;
                ARB_H2C:  if (host_rise_i) state_d = ARB_IDLE;
                default:  state_d = ARB_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/io_drive_ctrl.sv
// Drive-low output decode.
// The copying side is pulled low only while the source side's synchronized
// level is low. The card side is also held low whenever reception is not yet
// allowed. All gating is combinational, so loss of the enable releases the
// outputs without waiting for a clock edge.
// Assumes: state comes from io_dir_fsm; levels come from io_line_sync.
module io_drive_ctrl
    import io_arb_pkg::*;
(
    input  arb_state_t state_i,
    input  logic       relay_en_i,
    input  logic       rx_enable_i,
    input  logic       card_level_i,
    input  logic       host_level_i,
    output logic       card_drive_lo_o,
    output logic       host_drive_lo_o
);

    logic active;

    // Combine the qualifiers and decode each output
    always_comb begin
        active          = relay_en_i & rx_enable_i;
        host_drive_lo_o = active & (state_i == ARB_C2H) & ~card_level_i;
        card_drive_lo_o = ~rx_enable_i |
                          (active & (state_i == ARB_H2C) & ~host_level_i);
    end

endmodule

// File: rtl/io_dir_arbiter.sv
// Top level of the half-duplex line direction arbiter, one per line pair.
// Synchronizes both lines, picks the direction from the first falling edge,
// and drives the copying side low while the source side is low.
// Assumes: external pull-ups; drive outputs control open-drain pads.
module io_dir_arbiter
    import io_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic relay_en,
    input  logic rx_enable,
    input  logic card_in,
    input  logic host_in,
    output logic card_drive_lo,
    output logic host_drive_lo
);

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] lvl;
    logic [NUM_LINES-1:0] fall;
    logic [NUM_LINES-1:0] rise;
    logic                 active;
    arb_state_t           state_q;

    // Gather the raw lines into the synchronizer bank order
    always_comb begin
        raw_lines            = '0;
        raw_lines[LINE_CARD] = card_in;
        raw_lines[LINE_HOST] = host_in;
        active               = relay_en & rx_enable;
    end

    io_line_sync #(
        .LINES      (NUM_LINES),
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (raw_lines),
        .level_o(lvl),
        .fall_o (fall),
        .rise_o (rise)
    );

    io_dir_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .card_fall_i(fall[LINE_CARD]),
        .card_rise_i(rise[LINE_CARD]),
        .host_fall_i(fall[LINE_HOST]),
        .host_rise_i(rise[LINE_HOST]),
        .state_o    (state_q)
    );

    io_drive_ctrl drv_i (
        .state_i        (state_q),
        .relay_en_i     (relay_en),
        .rx_enable_i    (rx_enable),
        .card_level_i   (lvl[LINE_CARD]),
        .host_level_i   (lvl[LINE_HOST]),
        .card_drive_lo_o(card_drive_lo),
        .host_drive_lo_o(host_drive_lo)
    );

endmodule

// File: rtl/io_dir_arbiter_chk.sv
// Assertion checker for io_dir_arbiter, attached with bind.
// Assumes: it observes the top-level ports and the direction state register.
module io_dir_arbiter_chk
    import io_arb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       relay_en,
    input logic       rx_enable,
    input logic       card_drive_lo,
    input logic       host_drive_lo,
    input arb_state_t arb_state
);

    // R2
    card_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |-> card_drive_lo);

    // R9
    relay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !relay_en |-> !host_drive_lo);

    // R3
    drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enable |-> !(card_drive_lo && host_drive_lo));

    // R5
    no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_state != ARB_IDLE) |=> (arb_state == $past(arb_state) || arb_state == ARB_IDLE));

    // R8
    idle_on_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !relay_en |=> (arb_state == ARB_IDLE));

endmodule

bind io_dir_arbiter io_dir_arbiter_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .relay_en     (relay_en),
    .rx_enable    (rx_enable),
    .card_drive_lo(card_drive_lo),
    .host_drive_lo(host_drive_lo),
    .arb_state    (state_q)
);

// File: tb/io_dir_arbiter_tb_top.sv
module io_dir_arbiter_tb_top;

    localparam int SYNC = 3;
    localparam int SETTLE = SYNC + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic relay_en = 1'b0;
    logic rx_enable = 1'b0;
    logic card_ext_lo = 1'b0;
    logic host_ext_lo = 1'b0;
    logic card_drive_lo;
    logic host_drive_lo;
    logic card_in;
    logic host_in;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // Wired-AND open-drain line models
    assign card_in = ~(card_ext_lo | card_drive_lo);
    assign host_in = ~(host_ext_lo | host_drive_lo);

    io_dir_arbiter #(.SYNC_STAGES(SYNC)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .relay_en     (relay_en),
        .rx_enable    (rx_enable),
        .card_in      (card_in),
        .host_in      (host_in),
        .card_drive_lo(card_drive_lo),
        .host_drive_lo(host_drive_lo)
    );

    // Expected drive of the copying side given the source side
    function automatic logic exp_card_drive(input logic src_is_card, input logic src_low);
        return (!src_is_card) && src_low;
    endfunction

    function automatic logic exp_host_drive(input logic src_is_card, input logic src_low);
        return src_is_card && src_low;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 card in reset", card_drive_lo, 1'b1);
        chk("R1 host in reset", host_drive_lo, 1'b0);
        rst_n = 1'b1;
        settle();
        chk("R1 card after reset", card_drive_lo, 1'b1);
        chk("R1 host after reset", host_drive_lo, 1'b0);

        // R2: relay on but reception blocked
        relay_en = 1'b1;
        host_ext_lo = 1'b1;
        settle();
        chk("R2 card held", card_drive_lo, 1'b1);
        chk("R2 host idle", host_drive_lo, 1'b0);
        host_ext_lo = 1'b0;
        settle();
        rx_enable = 1'b1;
        settle();
        chk("R2 card released", card_drive_lo, 1'b0);

        // R10: latency through the synchronizer
        card_ext_lo = 1'b1;
        repeat (SYNC) @(negedge clk);
        chk("R10 not yet", host_drive_lo, 1'b0);
        @(negedge clk);
        chk("R10 now", host_drive_lo, 1'b1);
        // R3 source card
        settle();
        chk("R3 host copy", host_drive_lo, 1'b1);
        chk("R3 card free", card_drive_lo, 1'b0);
        card_ext_lo = 1'b0;
        settle();
        // R5: release
        chk("R5 host rel", host_drive_lo, 1'b0);
        chk("R5 card rel", card_drive_lo, 1'b0);

        // R4: source host
        host_ext_lo = 1'b1;
        settle();
        chk("R4 card copy", card_drive_lo, 1'b1);
        chk("R4 host free", host_drive_lo, 1'b0);
        host_ext_lo = 1'b0;
        settle();
        chk("R5 after h2c", card_drive_lo, 1'b0);

        // R6: simultaneous falls
        card_ext_lo = 1'b1;
        host_ext_lo = 1'b1;
        settle();
        chk("R6 card wins host drv", host_drive_lo, 1'b1);
        chk("R6 card wins card drv", card_drive_lo, 1'b0);
        // R7: card rises while host still held low
        card_ext_lo = 1'b0;
        settle();
        chk("R7 no capture card", card_drive_lo, 1'b0);
        chk("R7 no capture host", host_drive_lo, 1'b0);
        host_ext_lo = 1'b0;
        settle();
        chk("R7 idle card", card_drive_lo, 1'b0);

        // R8: clearing enable releases at once
        card_ext_lo = 1'b1;
        settle();
        chk("R8 pre", host_drive_lo, 1'b1);
        relay_en = 1'b0;
        #1;
        chk("R8 immediate", host_drive_lo, 1'b0);
        settle();
        relay_en = 1'b1;
        settle();
        chk("R8 no recapture", host_drive_lo, 1'b0);
        card_ext_lo = 1'b0;
        settle();

        // R9: disabled relay ignores falls
        relay_en = 1'b0;
        card_ext_lo = 1'b1;
        settle();
        chk("R9 card fall", host_drive_lo, 1'b0);
        card_ext_lo = 1'b0;
        host_ext_lo = 1'b1;
        settle();
        chk("R9 host fall", card_drive_lo, 1'b0);
        host_ext_lo = 1'b0;
        relay_en = 1'b1;
        settle();

        // Random transfers: R3 R4 R5
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 60; i++) begin
            logic src_card;
            int extra;
            src_card = 1'($urandom % 2);
            extra = int'($urandom % 5);
            if (src_card) card_ext_lo = 1'b1;
            else          host_ext_lo = 1'b1;
            settle();
            repeat (extra) @(negedge clk);
            chk("R3/R4 random card", card_drive_lo, exp_card_drive(src_card, 1'b1));
            chk("R3/R4 random host", host_drive_lo, exp_host_drive(src_card, 1'b1));
            card_ext_lo = 1'b0;
            host_ext_lo = 1'b0;
            settle();
            chk("R5 random card", card_drive_lo, exp_card_drive(src_card, 1'b0));
            chk("R5 random host", host_drive_lo, exp_host_drive(src_card, 1'b0));
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule